// File: doc/BRIEF.md
# FIFO Status, Interrupt and DMA Request Unit

This block sits next to the transmit and receive FIFOs of a serial controller and turns their fill levels and push/pop strobes into the information software and a DMA engine need. The FIFOs report their current occupancy and the strobes they see each cycle. The block builds a status word, compares each level against a programmable threshold, and latches overflow and underflow errors until software clears them. It also raises one interrupt line whenever an unmasked cause is active.

Two DMA request lines, one per direction, are driven from per-direction enables and programmable data-level watermarks. A transmit request asks for refill while the transmit FIFO is low. A receive request asks for draining while the receive FIFO holds more than its watermark. All settings are reached through a small word-addressed register port with a combinational read path. A threshold or watermark register ignores writes of values at or above the FIFO depth. Software can therefore find the depth by writing increasing values and seeing where the read-back stops matching.

Top module: `fifo_status_irq`

## Requirements
- R1: The status word at address 0 has busy at bit 0, transmit full (level equals DEPTH) at bit 1, transmit empty (level 0) at bit 2, receive empty at bit 3 and receive full at bit 4, all following the inputs in the same cycle.
- R2: The raw interrupt word at address 1 has bit 0 set while the transmit level is less than or equal to the transmit threshold (address 5). It has bit 4 set while the receive level is greater than the receive threshold (address 6).
- R3: A transmit push while the transmit level equals DEPTH sets raw bit 1, and a receive push while the receive level equals DEPTH sets raw bit 3, one cycle after the strobe. A push below full sets nothing, and a set flag stays set until it is cleared.
- R4: A receive pop while the receive level is 0 sets raw bit 2 one cycle after the strobe, and the flag stays set until it is cleared.
- R5: Writing the clear register (address 4) clears flags selectively: bit 1 clears receive underflow, bit 2 clears receive overflow, bit 3 clears transmit overflow and bit 0 clears all three. Flags that are not named stay set. A new error in the same cycle as its clear leaves the flag set. The clear register reads as 0.
- R6: The mask register (address 2) gates the raw word. Address 3 reads raw AND mask, and irq_o is high exactly when that masked word is non-zero.
- R7: The transmit and receive thresholds (addresses 5 and 6) and the transmit and receive watermarks (addresses 10 and 11) accept values 0 to DEPTH-1. A write of DEPTH or more leaves the old value, which reads back unchanged.
- R8: Address 7 reads the transmit fill level and address 8 reads the receive fill level.
- R9: DMA enable (address 9) bit 1 enables transmit requests and bit 0 enables receive requests. tx_dma_req_o is high while enabled and the transmit level is at or below the transmit watermark. rx_dma_req_o is high while enabled and the receive level is above the receive watermark.
- R10: After reset all thresholds, watermarks, the mask, the DMA enables and the error flags are 0, irq_o is low and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Serial engine busy |
| tx_push_i | input | 1 | Transmit FIFO write strobe |
| tx_pop_i | input | 1 | Transmit FIFO read strobe |
| tx_level_i | input | LVL_W | Transmit FIFO fill count |
| rx_push_i | input | 1 | Receive FIFO write strobe |
| rx_pop_i | input | 1 | Receive FIFO read strobe |
| rx_level_i | input | LVL_W | Receive FIFO fill count |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Interrupt, any masked cause active |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
The bench uses the defaults: DEPTH of 16 with 16-bit register data, so levels run from 0 to 16. This small depth lets the bench drive both full and empty levels directly. It also lets it write exactly DEPTH and larger values such as 20 to the limit registers and see them rejected. It checks that DEPTH-1 is accepted, and that the at-or-below and above comparisons switch at the programmed value.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  typedef enum logic [3:0] {
    A_STATUS = 4'd0,
    A_RAW    = 4'd1,
    A_MASK   = 4'd2,
    A_MASKED = 4'd3,
    A_CLEAR  = 4'd4,
    A_TX_THR = 4'd5,
    A_RX_THR = 4'd6,
    A_TX_LVL = 4'd7,
    A_RX_LVL = 4'd8,
    A_DMA_EN = 4'd9,
    A_TX_WM  = 4'd10,
    A_RX_WM  = 4'd11
  } reg_addr_e;

  // interrupt word bit positions
  localparam int unsigned IB_TX_LOW = 0;
  localparam int unsigned IB_TX_OVF = 1;
  localparam int unsigned IB_RX_UDF = 2;
  localparam int unsigned IB_RX_OVF = 3;
  localparam int unsigned IB_RX_HIGH = 4;

  // clear register bit positions
  localparam int unsigned CB_ALL    = 0;
  localparam int unsigned CB_RX_UDF = 1;
  localparam int unsigned CB_RX_OVF = 2;
  localparam int unsigned CB_TX_OVF = 3;

  // sticky flag vector order
  localparam int unsigned EF_TX_OVF = 0;
  localparam int unsigned EF_RX_UDF = 1;
  localparam int unsigned EF_RX_OVF = 2;
  localparam int unsigned NUM_ERR   = 3;

  // limit register bank order
  localparam int unsigned LR_TX_THR = 0;
  localparam int unsigned LR_RX_THR = 1;
  localparam int unsigned LR_TX_WM  = 2;
  localparam int unsigned LR_RX_WM  = 3;
  localparam int unsigned NUM_LIM   = 4;

  localparam int unsigned INT_W = 5;
endpackage

// File: rtl/fsi_limit_reg.sv
// Level register that rejects writes at or above LIMIT.
module fsi_limit_reg #(
  parameter int unsigned W      = 5,
  parameter int unsigned DW     = 16,
  parameter int unsigned LIMIT  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  value_o
);
  logic in_range;
  assign in_range = (wdata_i < DW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  value_o <= '0;
    else if (wr_en_i && in_range) value_o <= wdata_i[W-1:0];
  end
endmodule

// File: rtl/fsi_err_flags.sv
// Sticky error flags; a set in the same cycle as a clear wins.
module fsi_err_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[g] <= 1'b0;
      else if (set_i[g]) flags_o[g] <= 1'b1;
      else if (clr_i[g]) flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_status_irq.sv
module fifo_status_irq
  import fsi_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              tx_push_i,
  input  logic              tx_pop_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic              rx_push_i,
  input  logic              rx_pop_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              tx_dma_req_o,
  output logic              rx_dma_req_o
);
  localparam logic [3:0] LIM_ADDR [NUM_LIM] = '{A_TX_THR, A_RX_THR, A_TX_WM, A_RX_WM};
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] lim_q [NUM_LIM];
  logic [INT_W-1:0] mask_q;
  logic [1:0]       dma_en_q;
  logic [INT_W-1:0] status_w, raw_w, masked_w;
  logic [NUM_ERR-1:0] err_set, err_clr, err_q;
  logic clr_wr;

  // tx_pop_i carries no error cause; kept for a uniform strobe interface
  logic unused_pop;
  assign unused_pop = tx_pop_i;

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    fsi_limit_reg #(.W(LVL_W), .DW(DATA_W), .LIMIT(DEPTH)) u_lim (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (reg_we_i && (reg_addr_i == LIM_ADDR[g])),
      .wdata_i (reg_wdata_i),
      .value_o (lim_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      dma_en_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_MASK)   mask_q   <= reg_wdata_i[INT_W-1:0];
      if (reg_addr_i == A_DMA_EN) dma_en_q <= reg_wdata_i[1:0];
    end
  end

  assign clr_wr = reg_we_i && (reg_addr_i == A_CLEAR);

  always_comb begin
    err_set[EF_TX_OVF] = tx_push_i && (tx_level_i == FULL_LVL);
    err_set[EF_RX_OVF] = rx_push_i && (rx_level_i == FULL_LVL);
    err_set[EF_RX_UDF] = rx_pop_i && (rx_level_i == '0);
    err_clr[EF_TX_OVF] = clr_wr && (reg_wdata_i[CB_ALL] || reg_wdata_i[CB_TX_OVF]);
    err_clr[EF_RX_OVF] = clr_wr && (reg_wdata_i[CB_ALL] || reg_wdata_i[CB_RX_OVF]);
    err_clr[EF_RX_UDF] = clr_wr && (reg_wdata_i[CB_ALL] || reg_wdata_i[CB_RX_UDF]);
  end

  fsi_err_flags #(.N(NUM_ERR)) u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (err_set),
    .clr_i   (err_clr),
    .flags_o (err_q)
  );

  always_comb begin
    status_w    = '0;
    status_w[0] = busy_i;
    status_w[1] = (tx_level_i == FULL_LVL);
    status_w[2] = (tx_level_i == '0);
    status_w[3] = (rx_level_i == '0);
    status_w[4] = (rx_level_i == FULL_LVL);

    raw_w             = '0;
    raw_w[IB_TX_LOW]  = (tx_level_i <= lim_q[LR_TX_THR]);
    raw_w[IB_TX_OVF]  = err_q[EF_TX_OVF];
    raw_w[IB_RX_UDF]  = err_q[EF_RX_UDF];
    raw_w[IB_RX_OVF]  = err_q[EF_RX_OVF];
    raw_w[IB_RX_HIGH] = (rx_level_i > lim_q[LR_RX_THR]);
  end

  assign masked_w     = raw_w & mask_q;
  assign irq_o        = |masked_w;
  assign tx_dma_req_o = dma_en_q[1] && (tx_level_i <= lim_q[LR_TX_WM]);
  assign rx_dma_req_o = dma_en_q[0] && (rx_level_i >  lim_q[LR_RX_WM]);

  always_comb begin
    case (reg_addr_i)
      A_STATUS: reg_rdata_o = DATA_W'(status_w);
      A_RAW:    reg_rdata_o = DATA_W'(raw_w);
      A_MASK:   reg_rdata_o = DATA_W'(mask_q);
      A_MASKED: reg_rdata_o = DATA_W'(masked_w);
      A_TX_THR: reg_rdata_o = DATA_W'(lim_q[LR_TX_THR]);
      A_RX_THR: reg_rdata_o = DATA_W'(lim_q[LR_RX_THR]);
      A_TX_LVL: reg_rdata_o = DATA_W'(tx_level_i);
      A_RX_LVL: reg_rdata_o = DATA_W'(rx_level_i);
      A_DMA_EN: reg_rdata_o = DATA_W'(dma_en_q);
      A_TX_WM:  reg_rdata_o = DATA_W'(lim_q[LR_TX_WM]);
      A_RX_WM:  reg_rdata_o = DATA_W'(lim_q[LR_RX_WM]);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fsi_checker.sv
module fsi_checker #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_push_i,
  input logic              rx_push_i,
  input logic              rx_pop_i,
  input logic [LVL_W-1:0]  tx_level_i,
  input logic [LVL_W-1:0]  rx_level_i,
  input logic              reg_we_i,
  input logic [3:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [2:0]        err_q,
  input logic [4:0]        status_w,
  input logic [4:0]        mask_q,
  input logic [1:0]        dma_en_q,
  input logic [LVL_W-1:0]  tx_thr_q,
  input logic              irq_o,
  input logic              tx_dma_req_o,
  input logic              rx_dma_req_o
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == 4'd4);

  assert_full_empty_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_w[1] && status_w[2]) && !(status_w[3] && status_w[4]));

  assert_tx_ovf_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && tx_level_i == LVL_W'(DEPTH)) |=> err_q[0]);

  assert_rx_ovf_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_level_i == LVL_W'(DEPTH)) |=> err_q[2]);

  assert_rx_udf_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && rx_level_i == '0) |=> err_q[1]);

  assert_tx_ovf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q[0] && !(clr_wr && (reg_wdata_i[0] || reg_wdata_i[3]))) |=> err_q[0]);

  assert_rx_udf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q[1] && !(clr_wr && (reg_wdata_i[0] || reg_wdata_i[1]))) |=> err_q[1]);

  assert_irq_needs_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0));

  assert_reject_big_thr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 4'd5 && reg_wdata_i >= DATA_W'(DEPTH)) |=> $stable(tx_thr_q));

  assert_dma_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_dma_req_o || dma_en_q[1]) && (!rx_dma_req_o || dma_en_q[0]));
endmodule

bind fifo_status_irq fsi_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_fsi_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_push_i    (tx_push_i),
  .rx_push_i    (rx_push_i),
  .rx_pop_i     (rx_pop_i),
  .tx_level_i   (tx_level_i),
  .rx_level_i   (rx_level_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .err_q        (err_q),
  .status_w     (status_w),
  .mask_q       (mask_q),
  .dma_en_q     (dma_en_q),
  .tx_thr_q     (lim_q[0]),
  .irq_o        (irq_o),
  .tx_dma_req_o (tx_dma_req_o),
  .rx_dma_req_o (rx_dma_req_o)
);

// File: tb/tb_fifo_status_irq.sv
`timescale 1ns/1ps
module tb_fifo_status_irq;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int LW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [LW-1:0] tx_lvl = '0, rx_lvl = '0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq, tx_req, rx_req;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fifo_status_irq #(.DEPTH(DEPTH), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy),
    .tx_push_i(tx_push), .tx_pop_i(tx_pop), .tx_level_i(tx_lvl),
    .rx_push_i(rx_push), .rx_pop_i(rx_pop), .rx_level_i(rx_lvl),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .tx_dma_req_o(tx_req), .rx_dma_req_o(rx_req)
  );

  // {tx_level, rx_level, busy, status, raw} with both thresholds at 0
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {5'd0,  5'd0,  1'b0, 5'h0C, 5'h01},
    {5'd16, 5'd0,  1'b1, 5'h0B, 5'h00},
    {5'd5,  5'd16, 1'b0, 5'h10, 5'h10},
    {5'd0,  5'd3,  1'b1, 5'h05, 5'h11},
    {5'd16, 5'd16, 1'b0, 5'h12, 5'h10},
    {5'd7,  5'd0,  1'b1, 5'h09, 5'h00}
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = DW'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = int'(rdata);
  endtask

  task automatic rd_chk(input string req, input int a, input int exp);
    int v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic set_lvl(input int t, input int r);
    @(negedge clk);
    tx_lvl = LW'(t); rx_lvl = LW'(r);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd_chk("R10", 5, 0); rd_chk("R10", 6, 0); rd_chk("R10", 10, 0); rd_chk("R10", 11, 0);
    rd_chk("R10", 2, 0); rd_chk("R10", 9, 0);
    rd_chk("R10", 1, 32'h01);
    check("R10", {29'd0, irq, tx_req, rx_req}, 0);

    // R1 R2 R8 table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tx_lvl = VEC[i][20:16]; rx_lvl = VEC[i][15:11]; busy = VEC[i][10];
      rd_chk("R1", 0, int'(VEC[i][9:5]));
      rd_chk("R2", 1, int'(VEC[i][4:0]));
      rd_chk("R8", 7, int'(VEC[i][20:16]));
      rd_chk("R8", 8, int'(VEC[i][15:11]));
    end
    busy = 1'b0;

    // R2 threshold edges
    wr(5, 5); wr(6, 9);
    set_lvl(5, 9);  rd_chk("R2", 1, 32'h01);
    set_lvl(6, 10); rd_chk("R2", 1, 32'h10);

    // R7 out-of-range writes rejected, DEPTH-1 accepted
    wr(5, 16); rd_chk("R7", 5, 5);
    wr(6, 20); rd_chk("R7", 6, 9);
    wr(10, 16); rd_chk("R7", 10, 0);
    wr(5, 15); rd_chk("R7", 5, 15);
    wr(11, 15); rd_chk("R7", 11, 15);
    wr(11, 0);

    // R3 push below full sets nothing
    set_lvl(15, 8);
    @(negedge clk); tx_push = 1'b1; rx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0; rx_push = 1'b0;
    rd(1, v); check("R3", v & 32'h0E, 0);
    // R3 R4 errors at full / empty
    set_lvl(16, 16);
    @(negedge clk); tx_push = 1'b1; rx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0; rx_push = 1'b0;
    set_lvl(8, 0);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    set_lvl(8, 8);
    repeat (3) @(negedge clk);
    rd(1, v); check("R3", v & 32'h0E, 32'h0E);

    // R5 selective clear
    wr(4, 32'h04); rd(1, v); check("R5", v & 32'h0E, 32'h06);
    wr(4, 32'h08); rd(1, v); check("R5", v & 32'h0E, 32'h04);
    rd_chk("R5", 4, 0);
    set_lvl(16, 16);
    @(negedge clk); tx_push = 1'b1; rx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0; rx_push = 1'b0;
    set_lvl(8, 8);
    wr(4, 32'h01); rd(1, v); check("R5", v & 32'h0E, 0);
    // set beats clear in the same cycle
    set_lvl(8, 0);
    @(negedge clk); rx_pop = 1'b1; we = 1'b1; addr = 4'd4; wdata = 16'h0002;
    @(negedge clk); rx_pop = 1'b0; we = 1'b0;
    set_lvl(8, 8);
    rd(1, v); check("R5", v & 32'h0E, 32'h04);

    // R6 masking; tx 8 <= thr 15 so raw bit0 set, rx_udf set
    wr(2, 0);     #1 check("R6", irq, 0);
    wr(2, 32'h02); #1 check("R6", irq, 0);
    rd_chk("R6", 3, 0);
    wr(2, 32'h04); #1 check("R6", irq, 1);
    rd_chk("R6", 3, 32'h04);
    wr(2, 32'h11); rd_chk("R6", 3, 32'h01);
    #1 check("R6", irq, 1);
    wr(4, 32'h01); wr(2, 32'h04); #1 check("R6", irq, 0);

    // R9 DMA requests
    wr(10, 4); wr(11, 4);
    set_lvl(0, 9); #1 check("R9", {30'd0, tx_req, rx_req}, 0);
    wr(9, 3);
    set_lvl(4, 5); #1 check("R9", {30'd0, tx_req, rx_req}, 3);
    set_lvl(5, 4); #1 check("R9", {30'd0, tx_req, rx_req}, 0);
    wr(9, 1);
    set_lvl(0, 5); #1 check("R9", {30'd0, tx_req, rx_req}, 1);
    wr(9, 2);
    set_lvl(0, 5); #1 check("R9", {30'd0, tx_req, rx_req}, 2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule